// File: doc/BRIEF.md
# Bounded Two-Button Up/Down Counter

This block keeps a 9-bit count that an operator steers with two push buttons, one marked up and one marked down. Both buttons and all state run on a single system clock with a synchronous active-high reset. Each raw button level first crosses into the clock domain through a two-stage flip-flop chain. It then passes through a stability filter that accepts a new level only after that level has held for a set number of cycles. A rising-edge detector on the filtered level then gives a single-cycle event pulse for each press.

One counter register, written from a single process, reacts to the two event pulses. The buttons do not count freely. An up press normally adds one, but once the count has climbed above 399 it takes one away instead. A down press normally takes one away, but while the count is below 200 it adds one instead. Near each threshold the count therefore swings back and forth. The count and both event pulses are outputs, so a display or another controller can follow them.

Top module: `updn_button_counter`

## Requirements
- R1: While reset is high and on the first cycle after it, the count reads 0 and both event outputs are low.
- R2: An up event alone, with the count at 399 or less, raises the count by exactly 1.
- R3: An up event alone, with the count above 399, lowers the count by exactly 1, so repeated up presses from 399 swing the count between 399 and 400.
- R4: A down event alone, with the count below 200, raises the count by exactly 1.
- R5: A down event alone, with the count at 200 or more, lowers the count by exactly 1, so repeated down presses from 200 swing the count between 200 and 199.
- R6: When up and down events occur in the same cycle, they cancel and the count does not change.
- R7: A button level that lasts fewer than STABLE_CYCLES clock cycles (16 by default) after synchronization produces no event and leaves the count unchanged.
- R8: Each accepted press produces exactly one event pulse, one cycle wide, on that button's event output. Releasing the button produces no pulse.
- R9: In a cycle with no event, the count holds its value.
- R10: Starting from reset, the count never exceeds 400.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every register samples on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| btn_up_i | input | 1 | Raw level of the up button, asynchronous, 1 = pressed |
| btn_dn_i | input | 1 | Raw level of the down button, asynchronous, 1 = pressed |
| count_o | output | 9 | Current count value |
| up_evt_o | output | 1 | One-cycle pulse for each accepted up press |
| dn_evt_o | output | 1 | One-cycle pulse for each accepted down press |

## Verification
A filter that holds a wrong level or a wrong cycle count shows up at the event outputs within one press. The pulse either goes missing, appears twice, or appears for a short glitch, and the count is off by one from the next settle point onward. A wrong turn comparison in the counter stays hidden until the count reaches 199, 200, 399 or 400. For that reason the stimulus walks the count all the way up to the upper turn and back down to the lower one, and reads the count after every press. A missed cancellation when both buttons fire together moves the count by one in a single press, and that is visible right away.

// File: rtl/updn_pkg.sv
package updn_pkg;

    localparam int DEF_COUNT_W  = 9;
    localparam int DEF_UP_TURN  = 399;
    localparam int DEF_DN_TURN  = 200;
    localparam int DEF_STABLE   = 16;
    localparam int NUM_BUTTONS  = 2;
    localparam int BTN_UP       = 0;
    localparam int BTN_DN       = 1;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_INC  = 2'd1,
        STEP_DEC  = 2'd2
    } step_e;

    typedef struct packed {
        logic dn;
        logic up;
    } evt_t;

    // Direction choice from the events and the two window comparisons.
    function automatic step_e pick_step(evt_t ev, logic over_up, logic under_dn);
        step_e s;
        s = STEP_HOLD;
        if (ev.up && !ev.dn) begin
            s = over_up ? STEP_DEC : STEP_INC;
        end else if (ev.dn && !ev.up) begin
            s = under_dn ? STEP_INC : STEP_DEC;
        end
        return s;
    endfunction

endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], raw_i};
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/btn_filter.sv
module btn_filter #(
    parameter int STABLE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_i,
    output logic level_o
);
    localparam int CW = $clog2(STABLE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);

    logic [CW-1:0] run_q;
    logic          level_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= '0;
            level_q <= 1'b0;
        end else if (sync_i == level_q) begin
            run_q <= '0;
        end else if (run_q == LAST) begin
            run_q   <= '0;
            level_q <= sync_i;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assign level_o = level_q;

    // R7
    filter_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run_q != LAST) |=> $stable(level_q));
endmodule

// File: rtl/edge_pulse.sv
module edge_pulse (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic pulse_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= level_i;
    end

    assign pulse_o = level_i && !prev_q && !rst;

    // R8
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_o |=> !pulse_o);
endmodule

// File: rtl/window_counter.sv
module window_counter
    import updn_pkg::*;
#(
    parameter int COUNT_W = DEF_COUNT_W,
    parameter int UP_TURN = DEF_UP_TURN,
    parameter int DN_TURN = DEF_DN_TURN
) (
    input  logic               clk,
    input  logic               rst,
    input  evt_t               evt_i,
    output logic [COUNT_W-1:0] count_o
);
    localparam logic [COUNT_W-1:0] UP_T = COUNT_W'(UP_TURN);
    localparam logic [COUNT_W-1:0] DN_T = COUNT_W'(DN_TURN);

    logic [COUNT_W-1:0] count_q;
    step_e              step;

    always_comb begin
        step = pick_step(evt_i, count_q > UP_T, count_q < DN_T);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else begin
            unique case (step)
                STEP_INC: count_q <= count_q + 1'b1;
                STEP_DEC: count_q <= count_q - 1'b1;
                default:  count_q <= count_q;
            endcase
        end
    end

    assign count_o = count_q;

    // R3
    up_turn_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_i.up && !evt_i.dn && count_q > UP_T) |=> (count_q == $past(count_q) - 1'b1));
    // R4
    dn_turn_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_i.dn && !evt_i.up && count_q < DN_T) |=> (count_q == $past(count_q) + 1'b1));
    // R6
    cancel_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_i.up && evt_i.dn) |=> $stable(count_q));
    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!evt_i.up && !evt_i.dn) |=> $stable(count_q));
    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        count_q <= UP_T + 1'b1);
endmodule

// File: rtl/updn_button_counter.sv
module updn_button_counter
    import updn_pkg::*;
#(
    parameter int COUNT_W       = DEF_COUNT_W,
    parameter int UP_TURN       = DEF_UP_TURN,
    parameter int DN_TURN       = DEF_DN_TURN,
    parameter int STABLE_CYCLES = DEF_STABLE,
    parameter int SYNC_STAGES   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               btn_up_i,
    input  logic               btn_dn_i,
    output logic [COUNT_W-1:0] count_o,
    output logic               up_evt_o,
    output logic               dn_evt_o
);
    logic [NUM_BUTTONS-1:0] raw;
    logic [NUM_BUTTONS-1:0] synced;
    logic [NUM_BUTTONS-1:0] level;
    logic [NUM_BUTTONS-1:0] pulse;
    evt_t                   evt;

    assign raw[BTN_UP] = btn_up_i;
    assign raw[BTN_DN] = btn_dn_i;

    for (genvar b = 0; b < NUM_BUTTONS; b++) begin : g_btn
        btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst(rst), .raw_i(raw[b]), .sync_o(synced[b])
        );
        btn_filter #(.STABLE_CYCLES(STABLE_CYCLES)) u_filt (
            .clk(clk), .rst(rst), .sync_i(synced[b]), .level_o(level[b])
        );
        edge_pulse u_edge (
            .clk(clk), .rst(rst), .level_i(level[b]), .pulse_o(pulse[b])
        );
    end

    assign evt.up = pulse[BTN_UP];
    assign evt.dn = pulse[BTN_DN];

    window_counter #(
        .COUNT_W(COUNT_W), .UP_TURN(UP_TURN), .DN_TURN(DN_TURN)
    ) u_count (
        .clk(clk), .rst(rst), .evt_i(evt), .count_o(count_o)
    );

    assign up_evt_o = evt.up;
    assign dn_evt_o = evt.dn;
endmodule

// File: tb/updn_button_counter_test.sv
module updn_button_counter_test;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 24;
    localparam int SETTLE     = 30;
    localparam int GLITCH     = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       up_b = 1'b0;
    logic       dn_b = 1'b0;
    logic [8:0] count;
    logic       up_evt, dn_evt;

    int errors = 0;
    int checks = 0;
    int up_n = 0;
    int dn_n = 0;
    int wide = 0;
    logic up_prev = 1'b0, dn_prev = 1'b0;

    updn_button_counter uut (
        .clk(clk), .rst(rst), .btn_up_i(up_b), .btn_dn_i(dn_b),
        .count_o(count), .up_evt_o(up_evt), .dn_evt_o(dn_evt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (up_evt) up_n++;
        if (dn_evt) dn_n++;
        if ((up_evt && up_prev) || (dn_evt && dn_prev)) wide++;
        up_prev <= up_evt;
        dn_prev <= dn_evt;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // op: 0 up, 1 down, 2 both, 3 up glitch, 4 down glitch
    task automatic do_op(input int op);
        up_n = 0; dn_n = 0;
        @(negedge clk);
        up_b = (op == 0 || op == 2 || op == 3);
        dn_b = (op == 1 || op == 2 || op == 4);
        repeat ((op >= 3) ? GLITCH : HOLD) @(negedge clk);
        up_b = 1'b0; dn_b = 1'b0;
        repeat (SETTLE) @(negedge clk);
    endtask

    localparam int NV = 9;
    localparam int OPS [NV] = '{0, 0, 1, 2, 3, 4, 1, 0, 0};
    localparam int EXP [NV] = '{1, 2, 3, 3, 3, 3, 4, 5, 6};

    function automatic int model(input int c, input int op);
        if (op == 0) return (c > 399) ? c - 1 : c + 1;
        if (op == 1) return (c < 200) ? c + 1 : c - 1;
        return c;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int exp_c;
        repeat (4) @(negedge clk);
        // R1 during reset
        check("R1 count in reset", count, 0);
        check("R1 evt in reset", up_evt | dn_evt, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 count after reset", count, 0);

        exp_c = 0;
        for (int i = 0; i < NV; i++) begin
            do_op(OPS[i]);
            check($sformatf("R2/R4/R6/R7 vector %0d", i), count, EXP[i]);
            exp_c = model(exp_c, OPS[i]);
            check("R9 model agrees", count, exp_c);
            if (OPS[i] == 0) check("R8 one up pulse", up_n, 1);
            if (OPS[i] == 1) check("R8 one dn pulse", dn_n, 1);
            if (OPS[i] >= 3) check("R7 glitch no pulse", up_n + dn_n, 0);
        end
        check("R8 pulses single cycle", wide, 0);

        // R2 climb to 399
        while (exp_c < 399) begin
            do_op(0);
            exp_c = model(exp_c, 0);
            if (count != exp_c) check("R2 climb", count, exp_c);
        end
        check("R2 reached 399", count, 399);
        do_op(0); check("R2 399 -> 400", count, 400);
        do_op(0); check("R3 400 -> 399", count, 399);
        do_op(0); check("R3 swing up 400", count, 400);
        do_op(0); check("R3 swing back 399", count, 399);
        do_op(0); check("R10 ceiling 400", count, 400);
        exp_c = 400;

        // R5 descend to 200
        while (exp_c > 200) begin
            do_op(1);
            exp_c = model(exp_c, 1);
            if (count != exp_c) check("R5 descend", count, exp_c);
        end
        check("R5 reached 200", count, 200);
        do_op(1); check("R5 200 -> 199", count, 199);
        do_op(1); check("R4 199 -> 200", count, 200);
        do_op(2); check("R6 cancel at turn", count, 200);
        check("R6 both pulses seen", up_n + dn_n, 2);
        do_op(4); check("R7 glitch at turn", count, 200);
        check("R8 pulses single cycle end", wide, 0);

        // R1 reset from mid-range
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 count cleared", count, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 count stays 0", count, 0);
        check("R1 no evt after reset", up_evt | dn_evt, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule